// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings a flat panel and its backlight out of reset in a fixed series of stages. Each stage raises one registered enable line: panel supply, LVDS link release, backlight supply, backlight PWM start, backlight enable. Between stages it holds off for a programmable number of milliseconds, which it counts with a 1 ms tick divided down from the system clock. The PWM generator is not part of this block. The block only raises its start line and hands on a fixed duty, divider and rate.

A request input drives progress. In run-through mode one request walks every stage to completion, waiting out each delay as it goes. In polled mode each request advances at most one stage, and a request that arrives while a delay is still running is dropped. Presence flags mark which of the optional enable lines are fitted on the board. A stage whose line is absent still takes place and still spends its delay. A failure flag sampled at the first stage sends the block to a terminal error state, and no enable line is ever raised from there.

Top module: `panel_pwr_seq`

## Requirements
- R1: Stages run in this fixed order: start, panel supply, LVDS release, backlight supply, PWM start, backlight enable, done. After reset every output is low.
- R2: When a request arrives in the start stage, the start stage runs on the clock edge that samples the request, with no wait before it.
- R3: After stage k runs (k = 0..3, start = 0), stage k+1 may run no earlier than delay entry k milliseconds later. `dly_i[16k +: 16]` holds entry k, and TICKS = CLK_HZ/1000 clock cycles make one millisecond. In run-through mode stage k+1 runs exactly entry_k*TICKS+1 cycles after stage k. A zero entry gives a gap of 1 cycle.
- R4: Stages with index 4 or higher add no delay. Backlight enable follows PWM start by one cycle, and done rises on the same edge as backlight enable.
- R5: `present_i` bit 0 marks the panel supply line, bit 1 the LVDS line, bit 2 the backlight supply line and bit 3 the backlight enable line. If a bit is clear, that line stays low, but its stage still happens and its delay still counts.
- R6: In polled mode (`run_all_i` = 0 at the request), a request outside the start stage advances exactly one stage if the previous stage's delay has expired. While the delay is running, the request is ignored. Without a request the block never advances.
- R7: In run-through mode (`run_all_i` = 1 at the request), a single request carries the block through every remaining stage to done.
- R8: Once PWM start is high, the duty output is 0xDF, the divider output is 1 and the rate output is 32768. Before that, all three are 0.
- R9: Once done is reached, further requests change no output.
- R10: If `start_fail_i` is high when the start stage runs, `error_o` rises. From then on no enable line rises and no request has any effect.
- R11: Every enable line, once high, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Sequencing request, sampled each clock |
| run_all_i | input | 1 | 1: run-through mode, 0: polled mode; sampled with a request |
| start_fail_i | input | 1 | Failure flag checked when the start stage runs |
| dly_i | input | NUM_DLY*DLY_W | Delay entries in ms; entry k at bits [k*DLY_W +: DLY_W] |
| present_i | input | 4 | Fitted flags: panel supply, LVDS, backlight supply, backlight enable (bit 0..3) |
| panel_vdd_en_o | output | 1 | Panel supply enable |
| lvds_en_o | output | 1 | LVDS shutdown release |
| bl_vdd_en_o | output | 1 | Backlight supply enable |
| pwm_start_o | output | 1 | Backlight PWM start |
| pwm_duty_o | output | 8 | PWM duty handed on |
| pwm_div_o | output | 4 | PWM divider handed on |
| pwm_hz_o | output | 16 | PWM rate in Hz handed on |
| bl_en_o | output | 1 | Backlight enable |
| done_o | output | 1 | Sequence complete |
| error_o | output | 1 | Start stage failed |

## Verification
The bench measures the exact cycle on which each enable line rises and compares it with a gap computed from the delay entries. An off-by-one prescaler or countdown would move every edge by a cycle per millisecond, and a design that lets stages 4 and 5 wait would put a gap between PWM start and backlight enable. Zero delays and absent lines are mixed in at random. A design that skipped an absent stage's delay would raise the next line too early. A design that waited forever on a zero entry would never reach done. Polled runs send requests while a delay is still running and check that they are dropped. They also leave the block idle after expiry and check that it does not advance by itself. They then send requests after done and after a start failure and check that the outputs stay as they were.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_PANEL = 3'd1,
    ST_LVDS  = 3'd2,
    ST_BLVDD = 3'd3,
    ST_PWM   = 3'd4,
    ST_BLEN  = 3'd5,
    ST_DONE  = 3'd6,
    ST_ERR   = 3'd7
  } stage_e;

  localparam int unsigned NUM_RUN   = 6;  // stages that execute (start..backlight enable)
  localparam int unsigned NUM_GPIO  = 4;
  localparam int unsigned DUTY_W    = 8;
  localparam int unsigned DIV_W     = 4;
  localparam int unsigned HZ_W      = 16;
  localparam logic [DUTY_W-1:0] PWM_DUTY = 8'hDF;
  localparam logic [DIV_W-1:0]  PWM_DIV  = 4'd1;
  localparam logic [HZ_W-1:0]   PWM_HZ   = 16'd32768;

  // stage index that drives optional line g
  function automatic int unsigned gpio_stage(int unsigned g);
    return (g < 3) ? g + 1 : 5;
  endfunction
endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
  parameter int unsigned TICKS = 8,
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             expired_o
);
  localparam int unsigned PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DLY_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      rem_q <= val_i;
    end else if (rem_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        rem_q <= rem_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (rem_q == '0);

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rem_q != '0) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1));
  p_prescale_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int unsigned NUM_DLY = 4,
  parameter int unsigned DLY_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     run_all_i,
  input  logic                     fail_i,
  input  logic                     expired_i,
  input  logic [NUM_DLY*DLY_W-1:0] dly_i,
  output logic                     load_o,
  output logic [DLY_W-1:0]         load_val_o,
  output logic [NUM_RUN-1:0]       run_o,
  output logic                     done_o,
  output logic                     err_o
);
  stage_e cur_q;
  logic   auto_q;
  logic   active, at_start, fire, fail_now, adv;

  always_comb begin
    active   = (cur_q != ST_DONE) && (cur_q != ST_ERR);
    at_start = (cur_q == ST_START);
    fire     = active && (at_start ? req_i : ((req_i || auto_q) && expired_i));
    fail_now = fire && at_start && fail_i;
    adv      = fire && !fail_now;
  end

  always_comb begin
    load_val_o = '0;
    for (int k = 0; k < NUM_DLY; k++) begin
      if (32'(cur_q) == k) load_val_o = dly_i[k*DLY_W +: DLY_W];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_RUN; k++) run_o[k] = adv && (32'(cur_q) == k);
  end

  assign load_o = adv;
  assign done_o = (cur_q == ST_DONE);
  assign err_o  = (cur_q == ST_ERR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= ST_START;
      auto_q <= 1'b0;
    end else begin
      if (fail_now)  cur_q <= ST_ERR;
      else if (adv)  cur_q <= stage_e'(3'(cur_q) + 3'd1);
      if (!active)                    auto_q <= 1'b0;
      else if (req_i && run_all_i)    auto_q <= 1'b1;
    end
  end

  p_hold_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != ST_START && !expired_i) |=> $stable(cur_q));
  p_step_by_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> (cur_q == ST_ERR || 3'(cur_q) == 3'($past(cur_q)) + 3'd1));
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == ST_DONE) |=> (cur_q == ST_DONE));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == ST_ERR) |=> (cur_q == ST_ERR));
  p_polled_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !auto_q) |=> $stable(cur_q));
endmodule

// File: rtl/pps_outputs.sv
module pps_outputs
  import pps_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_RUN-1:0]  run_i,
  input  logic [NUM_GPIO-1:0] present_i,
  output logic [NUM_GPIO-1:0] gpio_o,
  output logic                pwm_o
);
  logic [NUM_GPIO-1:0] gpio_q;
  logic                pwm_q;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_line
    localparam int unsigned STG = gpio_stage(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gpio_q[g] <= 1'b0;
      else if (run_i[STG] && present_i[g]) gpio_q[g] <= 1'b1;
    end

    p_hold_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(gpio_q[g]));
    p_absent_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!present_i[g] && !gpio_q[g]) |=> !gpio_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else if (run_i[ST_PWM]) pwm_q <= 1'b1;
  end

  assign gpio_o = gpio_q;
  assign pwm_o  = pwm_q;

  p_pwm_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(pwm_q));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned NUM_DLY = 4,
  parameter int unsigned DLY_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     run_all_i,
  input  logic                     start_fail_i,
  input  logic [NUM_DLY*DLY_W-1:0] dly_i,
  input  logic [3:0]               present_i,
  output logic                     panel_vdd_en_o,
  output logic                     lvds_en_o,
  output logic                     bl_vdd_en_o,
  output logic                     pwm_start_o,
  output logic [7:0]               pwm_duty_o,
  output logic [3:0]               pwm_div_o,
  output logic [15:0]              pwm_hz_o,
  output logic                     bl_en_o,
  output logic                     done_o,
  output logic                     error_o
);
  localparam int unsigned TICKS = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 1;

  logic               load, expired;
  logic [DLY_W-1:0]   load_val;
  logic [NUM_RUN-1:0] run;
  logic [NUM_GPIO-1:0] gpio;
  logic               pwm;

  pps_ctrl #(.NUM_DLY(NUM_DLY), .DLY_W(DLY_W)) i_ctrl (
    .clk_i, .rst_ni, .req_i, .run_all_i,
    .fail_i     (start_fail_i),
    .expired_i  (expired),
    .dly_i,
    .load_o     (load),
    .load_val_o (load_val),
    .run_o      (run),
    .done_o,
    .err_o      (error_o)
  );

  pps_ms_timer #(.TICKS(TICKS), .DLY_W(DLY_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i    (load),
    .val_i     (load_val),
    .expired_o (expired)
  );

  pps_outputs i_outs (
    .clk_i, .rst_ni,
    .run_i     (run),
    .present_i (present_i),
    .gpio_o    (gpio),
    .pwm_o     (pwm)
  );

  assign panel_vdd_en_o = gpio[0];
  assign lvds_en_o      = gpio[1];
  assign bl_vdd_en_o    = gpio[2];
  assign bl_en_o        = gpio[3];
  assign pwm_start_o    = pwm;
  assign pwm_duty_o     = pwm ? PWM_DUTY : '0;
  assign pwm_div_o      = pwm ? PWM_DIV  : '0;
  assign pwm_hz_o       = pwm ? PWM_HZ   : '0;

  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !(panel_vdd_en_o || lvds_en_o || bl_vdd_en_o || pwm_start_o || bl_en_o));
  p_blen_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bl_en_o) |-> done_o);
  p_blen_after_pwm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_en_o |-> pwm_start_o);
  p_done_has_pwm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pwm_start_o);
endmodule

// File: tb/test_panel_pwr_seq.sv
`timescale 1ns/1ps
module test_panel_pwr_seq;
  localparam int unsigned CLK_HZ = 8000;
  localparam int unsigned T = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, run_all = 1'b0, fail = 1'b0;
  logic [63:0] dly = '0;
  logic [3:0]  present = 4'hF;
  logic        panel, lvds, blvdd, pwm, blen, done, err;
  logic [7:0]  duty;
  logic [3:0]  div;
  logic [15:0] hz;

  int checks = 0, errors = 0, cyc = 0, c0 = 0;
  bit finished = 0;
  int d[4];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_pwr_seq #(.CLK_HZ(CLK_HZ)) i_panel_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .run_all_i(run_all),
    .start_fail_i(fail), .dly_i(dly), .present_i(present),
    .panel_vdd_en_o(panel), .lvds_en_o(lvds), .bl_vdd_en_o(blvdd),
    .pwm_start_o(pwm), .pwm_duty_o(duty), .pwm_div_o(div), .pwm_hz_o(hz),
    .bl_en_o(blen), .done_o(done), .error_o(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {blen, pwm, blvdd, lvds, panel};
  endfunction

  // stage k (1..5) output, by bench mapping
  function automatic bit stage_out(int k);
    case (k)
      1: return panel;  2: return lvds;  3: return blvdd;
      4: return pwm;    default: return blen;
    endcase
  endfunction

  function automatic bit stage_fitted(int k);
    case (k)
      1: return present[0]; 2: return present[1]; 3: return present[2];
      4: return 1'b1;       default: return present[3];
    endcase
  endfunction

  // cycles from start-stage edge to stage k edge
  function automatic int exp_time(int k);
    int t = 0;
    for (int j = 0; j < k; j++) t += ((j < 4) ? d[j] * T : 0) + 1;
    return t;
  endfunction

  task automatic load_dly();
    for (int k = 0; k < 4; k++) dly[k*16 +: 16] = 16'(d[k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; fail = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    req = 1'b1; c0 = cyc;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_through(input string tag);
    int first[6];
    int limit;
    for (int k = 0; k < 6; k++) first[k] = -1;
    load_dly();
    run_all = 1'b1;
    pulse();
    limit = exp_time(5) + 20;
    for (int n = 0; n < limit; n++) begin
      for (int k = 1; k <= 5; k++)
        if (stage_out(k) && first[k] < 0) first[k] = cyc - c0 - 1;
      if (done && first[0] < 0) first[0] = cyc - c0 - 1;
      @(negedge clk);
    end
    for (int k = 1; k <= 5; k++) begin
      if (stage_fitted(k))
        chk(first[k] == exp_time(k), $sformatf("R3 R7 %s stage %0d edge", tag, k),
            first[k], exp_time(k));
      else
        chk(first[k] == -1, $sformatf("R5 %s absent stage %0d", tag, k), first[k], -1);
    end
    chk(first[0] == exp_time(5), $sformatf("R4 %s done edge", tag), first[0], exp_time(5));
    chk(duty == 8'hDF && div == 4'd1 && hz == 16'd32768, $sformatf("R8 %s pwm params", tag),
        {duty, div, hz}, {8'hDF, 4'd1, 16'd32768});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk(outs() == 5'b0 && !done && !err, "R1 reset outputs low", {outs(), done, err}, 0);
    chk(duty == 0 && div == 0 && hz == 0, "R8 pwm params zero before start", {duty, div, hz}, 0);

    // directed run-through: all zero delays, all fitted
    d = '{0, 0, 0, 0};
    present = 4'hF;
    run_through("zero");
    // R11 hold
    repeat (200) @(negedge clk);
    chk(outs() == 5'h1F && done, "R11 lines stay high", outs(), 5'h1F);

    // directed run-through: larger delays
    do_reset();
    d = '{20, 3, 11, 7};
    present = 4'hF;
    run_through("long");
    do_reset();
    chk(outs() == 5'b0 && !done, "R11 reset clears lines", outs(), 0);

    // directed absent lines
    d = '{2, 5, 1, 4};
    present = 4'b0101;
    run_through("absent");

    // random run-through mixes
    for (int r = 0; r < 8; r++) begin
      do_reset();
      for (int k = 0; k < 4; k++) d[k] = $urandom_range(0, 6);
      present = 4'($urandom_range(0, 15));
      run_through($sformatf("rnd%0d", r));
    end

    // polled mode
    do_reset();
    d = '{2, 1, 0, 3};
    load_dly();
    present = 4'hF;
    run_all = 1'b0;
    pulse();                       // R2 start runs at once
    chk(!panel && !done && !err, "R2 start stage drives nothing", outs(), 0);
    pulse();                       // delay 0 (16 cycles) still running
    repeat (3) @(negedge clk);
    chk(!panel, "R6 early poll ignored", panel, 0);
    repeat (30) @(negedge clk);
    chk(!panel, "R6 no self advance in polled mode", panel, 0);
    pulse();
    chk(panel && !lvds, "R6 poll advances one stage", outs(), 1);
    pulse();
    chk(!lvds, "R6 poll during delay 1 ignored", lvds, 0);
    repeat (12) @(negedge clk);
    pulse();
    chk(lvds && !blvdd, "R6 poll advances to LVDS", outs(), 3);
    pulse();
    chk(blvdd && !pwm, "R3 zero delay allows next poll", outs(), 7);
    repeat (40) @(negedge clk);
    pulse();
    chk(pwm && !blen && duty == 8'hDF, "R8 pwm started by poll", outs(), 15);
    pulse();
    chk(blen && done, "R4 no delay after pwm stage", {blen, done}, 3);
    run_all = 1'b1;
    pulse();
    pulse();
    repeat (20) @(negedge clk);
    chk(outs() == 5'h1F && done && !err, "R9 requests after done no effect",
        {outs(), done, err}, {5'h1F, 1'b1, 1'b0});

    // failure at start
    do_reset();
    d = '{0, 0, 0, 0};
    load_dly();
    fail = 1'b1;
    run_all = 1'b1;
    pulse();
    chk(err && outs() == 5'b0, "R10 failure sets error", {err, outs()}, {1'b1, 5'b0});
    fail = 1'b0;
    pulse();
    repeat (50) @(negedge clk);
    chk(err && outs() == 5'b0 && !done, "R10 error is terminal", {err, outs(), done},
        {1'b1, 5'b0, 1'b0});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule